// File: doc/BRIEF.md
# Host address decoder

The block sorts each host memory request into one destination. The possible destinations are system DRAM, an engine-private region at the top of memory, a device register window, a remap-engine register window, the integrated graphics windows, one of the PCI Express ports, or the default downstream chipset link. Each request carries an address and a requester tag. The tag says whether the request comes from the processor side or from the management engine, which arrives through the chipset side. The decoder also watches its own configuration and flags a graphics or port window that reaches into the fixed interrupt-controller, message-interrupt or boot-firmware subranges just below 4 GB.

All configuration values arrive as plain input buses: top of memory, stolen size, top of low usable DRAM, window bases and limits, and enables. Registers outside the block hold them. A request presented with `req_valid` is decoded by combinational logic. The result is registered and appears on the next clock edge as a one-hot route with a valid strobe. The block has no state machine. Its only state is this single output register stage and the registered configuration-error flag.

Top module: `host_addr_decoder`

## Requirements
- R1: A request sampled with `req_valid` high produces `dst_valid` high on the next edge. With `dst_valid` high and `dst_illegal` low, `dst_route` has exactly one bit set. With `dst_valid` low, `dst_route` is all zero. Route bit 0 is DRAM, bit 1 the engine-private region, bit 2 device registers, bit 3 remap registers, bit 4 graphics, bit 5 the downstream link, and bit 6+p PCI Express port p.
- R2: The engine-private region runs from `cfg_tom - cfg_stolen` (inclusive) up to `cfg_tom` (exclusive). It has priority over every other rule. An engine request inside it routes to bit 1 and raises `dst_bypass_remap`.
- R3: A processor-side request inside the engine-private region raises `dst_illegal` and leaves `dst_route` all zero.
- R4: Outside the private region, an address below `cfg_tolud` routes to DRAM. An address at or above 4 GB routes to DRAM below `cfg_tom` and to the link at or above it.
- R5: An address in [`cfg_tolud`, 4 GB) that matches no window routes to the downstream link.
- R6: The three device register windows (index 0 egress port, 1 memory controller, 2 link registers) route to bit 2 when their own enable bit is set.
- R7: The three remap register windows (0 graphics, 1 link VC1, 2 port/link VC0) route to bit 3 only while `cfg_vt_en` is high.
- R8: The graphics windows (0 aperture, 1 translation table/registers) route to bit 4 only while `cfg_gfx_en` is high.
- R9: Port p owns window 2p (non-prefetchable) and window 2p+1 (prefetchable). A hit in either routes to bit 6+p. If several ports hit, the lowest port number wins.
- R10: Within the hole, the window kinds rank as device > remap > graphics > port > link.
- R11: Window bounds are inclusive at both base and limit. A window whose base exceeds its limit never matches.
- R12: `cfg_err` is high, one edge after the configuration settles, when any active graphics window or any valid port window overlaps [0xFEC00000,0xFECFFFFF], [0xFEE00000,0xFEEFFFFF] or [0xFF000000,0xFFFFFFFF].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | AW | Request address |
| req_from_engine | input | 1 | 1 = management engine requester, 0 = processor side |
| cfg_tom | input | AW | Top of memory |
| cfg_stolen | input | AW | Size of the engine-private region |
| cfg_tolud | input | AW | Top of low usable DRAM |
| cfg_dev_en | input | 3 | Device register window enables |
| cfg_dev_base | input | 3×AW | Device window bases |
| cfg_dev_limit | input | 3×AW | Device window limits |
| cfg_vt_en | input | 1 | Remap windows active |
| cfg_rmp_base | input | 3×AW | Remap window bases |
| cfg_rmp_limit | input | 3×AW | Remap window limits |
| cfg_gfx_en | input | 1 | Graphics windows active |
| cfg_gfx_base | input | 2×AW | Graphics window bases |
| cfg_gfx_limit | input | 2×AW | Graphics window limits |
| cfg_port_base | input | 2·NPORT×AW | Port window bases |
| cfg_port_limit | input | 2·NPORT×AW | Port window limits |
| dst_valid | output | 1 | Decoded result valid |
| dst_route | output | 6+NPORT | One-hot destination |
| dst_illegal | output | 1 | Forbidden processor access to private region |
| dst_bypass_remap | output | 1 | Engine access that skips the remap engines |
| cfg_err | output | 1 | Window overlaps a reserved subrange |

## Verification
Every decode result is due exactly one edge after the request. The bench drives a request on a falling edge, lets one rising edge register it, and reads all outputs at the following falling edge. It then drops `req_valid` before the next edge. The configuration-error flag is also one edge behind its inputs. Configuration changes are therefore applied on a falling edge and checked at the next falling edge.

// File: rtl/hadec_pkg.sv
package hadec_pkg;
    localparam int DST_DRAM  = 0;
    localparam int DST_RSV   = 1;
    localparam int DST_DEV   = 2;
    localparam int DST_RMP   = 3;
    localparam int DST_GFX   = 4;
    localparam int DST_LINK  = 5;
    localparam int DST_PORT0 = 6;

    localparam int NUM_DEV      = 3;
    localparam int NUM_RMP      = 3;
    localparam int NUM_GFX      = 2;
    localparam int WIN_PER_PORT = 2;
    localparam int NUM_SUB      = 3;

    localparam logic [31:0] SUB_BASE [NUM_SUB] = '{32'hFEC0_0000, 32'hFEE0_0000, 32'hFF00_0000};
    localparam logic [31:0] SUB_LIM  [NUM_SUB] = '{32'hFECF_FFFF, 32'hFEEF_FFFF, 32'hFFFF_FFFF};
endpackage

// File: rtl/hadec_window.sv
module hadec_window #(
    parameter int AW = 36
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  logic          en,
    output logic          hit
);
    always_comb begin
        hit = en && (base <= limit) && (addr >= base) && (addr <= limit);
    end
endmodule

// File: rtl/hadec_overlap_chk.sv
module hadec_overlap_chk
    import hadec_pkg::*;
#(
    parameter int AW = 36,
    parameter int NW = 6
) (
    input  logic [NW-1:0][AW-1:0] base,
    input  logic [NW-1:0][AW-1:0] limit,
    input  logic [NW-1:0]         en,
    output logic                  err
);
    logic [NW-1:0][NUM_SUB-1:0] clash;

    for (genvar w = 0; w < NW; w++) begin : g_win
        for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
            localparam logic [AW-1:0] SB = AW'(SUB_BASE[s]);
            localparam logic [AW-1:0] SL = AW'(SUB_LIM[s]);
            always_comb begin
                clash[w][s] = en[w] && (base[w] <= limit[w])
                              && (base[w] <= SL) && (SB <= limit[w]);
            end
        end
    end

    always_comb err = |clash;
endmodule

// File: rtl/hadec_route.sv
module hadec_route
    import hadec_pkg::*;
#(
    parameter int AW    = 36,
    parameter int NPORT = 2
) (
    input  logic [AW-1:0]             addr,
    input  logic                      from_engine,
    input  logic [AW-1:0]             tom,
    input  logic [AW-1:0]             stolen,
    input  logic [AW-1:0]             tolud,
    input  logic [NUM_DEV-1:0]        dev_hit,
    input  logic [NUM_RMP-1:0]        rmp_hit,
    input  logic [NUM_GFX-1:0]        gfx_hit,
    input  logic [NPORT-1:0]          port_hit,
    output logic [DST_PORT0+NPORT-1:0] route,
    output logic                      illegal,
    output logic                      bypass
);
    localparam int NDST = DST_PORT0 + NPORT;
    localparam logic [AW-1:0] FOUR_G = AW'(64'h1_0000_0000);

    logic [AW-1:0] rsv_base;
    logic          in_rsv;

    always_comb begin
        rsv_base = tom - stolen;
        in_rsv   = (stolen != '0) && (addr >= rsv_base) && (addr < tom);
    end

    always_comb begin
        route   = '0;
        illegal = 1'b0;
        bypass  = 1'b0;
        if (in_rsv) begin
            if (from_engine) begin
                route[DST_RSV] = 1'b1;
                bypass         = 1'b1;
            end else begin
                illegal = 1'b1;
            end
        end else if (addr < tolud) begin
            route[DST_DRAM] = 1'b1;
        end else if (addr < FOUR_G) begin
            if (|dev_hit) begin
                route[DST_DEV] = 1'b1;
            end else if (|rmp_hit) begin
                route[DST_RMP] = 1'b1;
            end else if (|gfx_hit) begin
                route[DST_GFX] = 1'b1;
            end else if (|port_hit) begin
                for (int p = NPORT - 1; p >= 0; p--) begin
                    if (port_hit[p]) begin
                        route                 = '0;
                        route[DST_PORT0 + p]  = 1'b1;
                    end
                end
            end else begin
                route[DST_LINK] = 1'b1;
            end
        end else if (addr < tom) begin
            route[DST_DRAM] = 1'b1;
        end else begin
            route[DST_LINK] = 1'b1;
        end
    end

    logic unused_ok;
    always_comb unused_ok = (NDST > 0);
endmodule

// File: rtl/host_addr_decoder.sv
module host_addr_decoder
    import hadec_pkg::*;
#(
    parameter int AW    = 36,
    parameter int NPORT = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     req_valid,
    input  logic [AW-1:0]                            req_addr,
    input  logic                                     req_from_engine,
    input  logic [AW-1:0]                            cfg_tom,
    input  logic [AW-1:0]                            cfg_stolen,
    input  logic [AW-1:0]                            cfg_tolud,
    input  logic [NUM_DEV-1:0]                       cfg_dev_en,
    input  logic [NUM_DEV-1:0][AW-1:0]               cfg_dev_base,
    input  logic [NUM_DEV-1:0][AW-1:0]               cfg_dev_limit,
    input  logic                                     cfg_vt_en,
    input  logic [NUM_RMP-1:0][AW-1:0]               cfg_rmp_base,
    input  logic [NUM_RMP-1:0][AW-1:0]               cfg_rmp_limit,
    input  logic                                     cfg_gfx_en,
    input  logic [NUM_GFX-1:0][AW-1:0]               cfg_gfx_base,
    input  logic [NUM_GFX-1:0][AW-1:0]               cfg_gfx_limit,
    input  logic [WIN_PER_PORT*NPORT-1:0][AW-1:0]    cfg_port_base,
    input  logic [WIN_PER_PORT*NPORT-1:0][AW-1:0]    cfg_port_limit,
    output logic                                     dst_valid,
    output logic [DST_PORT0+NPORT-1:0]               dst_route,
    output logic                                     dst_illegal,
    output logic                                     dst_bypass_remap,
    output logic                                     cfg_err
);
    localparam int NDST  = DST_PORT0 + NPORT;
    localparam int NPWIN = WIN_PER_PORT * NPORT;
    localparam int NCHK  = NUM_GFX + NPWIN;

    logic [NUM_DEV-1:0] dev_hit;
    logic [NUM_RMP-1:0] rmp_hit;
    logic [NUM_GFX-1:0] gfx_hit;
    logic [NPWIN-1:0]   pwin_hit;
    logic [NPORT-1:0]   port_hit;

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        hadec_window #(.AW(AW)) u_win (
            .addr(req_addr), .base(cfg_dev_base[i]), .limit(cfg_dev_limit[i]),
            .en(cfg_dev_en[i]), .hit(dev_hit[i]));
    end

    for (genvar i = 0; i < NUM_RMP; i++) begin : g_rmp
        hadec_window #(.AW(AW)) u_win (
            .addr(req_addr), .base(cfg_rmp_base[i]), .limit(cfg_rmp_limit[i]),
            .en(cfg_vt_en), .hit(rmp_hit[i]));
    end

    for (genvar i = 0; i < NUM_GFX; i++) begin : g_gfx
        hadec_window #(.AW(AW)) u_win (
            .addr(req_addr), .base(cfg_gfx_base[i]), .limit(cfg_gfx_limit[i]),
            .en(cfg_gfx_en), .hit(gfx_hit[i]));
    end

    for (genvar i = 0; i < NPWIN; i++) begin : g_pwin
        hadec_window #(.AW(AW)) u_win (
            .addr(req_addr), .base(cfg_port_base[i]), .limit(cfg_port_limit[i]),
            .en(1'b1), .hit(pwin_hit[i]));
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_comb port_hit[p] = |pwin_hit[WIN_PER_PORT*p +: WIN_PER_PORT];
    end

    logic [NDST-1:0] nxt_route;
    logic            nxt_illegal;
    logic            nxt_bypass;

    hadec_route #(.AW(AW), .NPORT(NPORT)) u_route (
        .addr(req_addr), .from_engine(req_from_engine),
        .tom(cfg_tom), .stolen(cfg_stolen), .tolud(cfg_tolud),
        .dev_hit(dev_hit), .rmp_hit(rmp_hit), .gfx_hit(gfx_hit), .port_hit(port_hit),
        .route(nxt_route), .illegal(nxt_illegal), .bypass(nxt_bypass));

    logic [NCHK-1:0][AW-1:0] chk_base;
    logic [NCHK-1:0][AW-1:0] chk_limit;
    logic [NCHK-1:0]         chk_en;
    logic                    nxt_err;

    always_comb begin
        for (int i = 0; i < NUM_GFX; i++) begin
            chk_base[i]  = cfg_gfx_base[i];
            chk_limit[i] = cfg_gfx_limit[i];
            chk_en[i]    = cfg_gfx_en;
        end
        for (int i = 0; i < NPWIN; i++) begin
            chk_base[NUM_GFX + i]  = cfg_port_base[i];
            chk_limit[NUM_GFX + i] = cfg_port_limit[i];
            chk_en[NUM_GFX + i]    = 1'b1;
        end
    end

    hadec_overlap_chk #(.AW(AW), .NW(NCHK)) u_ovl (
        .base(chk_base), .limit(chk_limit), .en(chk_en), .err(nxt_err));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_valid        <= 1'b0;
            dst_route        <= '0;
            dst_illegal      <= 1'b0;
            dst_bypass_remap <= 1'b0;
            cfg_err          <= 1'b0;
        end else begin
            dst_valid        <= req_valid;
            dst_route        <= req_valid ? nxt_route : '0;
            dst_illegal      <= req_valid && nxt_illegal;
            dst_bypass_remap <= req_valid && nxt_bypass;
            cfg_err          <= nxt_err;
        end
    end
endmodule

// File: rtl/host_addr_decoder_chk.sv
module host_addr_decoder_chk
    import hadec_pkg::*;
#(
    parameter int AW    = 36,
    parameter int NPORT = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_from_engine,
    input logic                       cfg_vt_en,
    input logic                       cfg_gfx_en,
    input logic                       dst_valid,
    input logic [DST_PORT0+NPORT-1:0] dst_route,
    input logic                       dst_illegal,
    input logic                       dst_bypass_remap
);
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dst_valid); // R1
    AST_IDLE_NO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_valid |-> (dst_route == '0)); // R1
    AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !dst_illegal) |-> ($countones(dst_route) == 1)); // R1
    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        dst_illegal |-> (dst_route == '0)); // R3
    AST_ILLEGAL_FROM_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        dst_illegal |-> !$past(req_from_engine)); // R3
    AST_BYPASS_RSV: assert property (@(posedge clk) disable iff (!rst_n)
        dst_bypass_remap |-> (dst_route[DST_RSV] && $past(req_from_engine))); // R2
    AST_RSV_ENGINE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        dst_route[DST_RSV] |-> $past(req_from_engine)); // R2
    AST_REMAP_NEEDS_VT: assert property (@(posedge clk) disable iff (!rst_n)
        dst_route[DST_RMP] |-> $past(cfg_vt_en)); // R7
    AST_GFX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        dst_route[DST_GFX] |-> $past(cfg_gfx_en)); // R8
endmodule

bind host_addr_decoder host_addr_decoder_chk #(.AW(AW), .NPORT(NPORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_from_engine(req_from_engine),
    .cfg_vt_en(cfg_vt_en), .cfg_gfx_en(cfg_gfx_en), .dst_valid(dst_valid),
    .dst_route(dst_route), .dst_illegal(dst_illegal), .dst_bypass_remap(dst_bypass_remap));

// File: tb/host_addr_decoder_tb_top.sv
module host_addr_decoder_tb_top;
    localparam int AW    = 36;
    localparam int NPORT = 2;
    localparam int NDST  = 6 + NPORT;
    localparam int NONE  = -1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                    req_valid = 1'b0;
    logic [AW-1:0]           req_addr = '0;
    logic                    req_from_engine = 1'b0;
    logic [AW-1:0]           cfg_tom, cfg_stolen, cfg_tolud;
    logic [2:0]              cfg_dev_en;
    logic [2:0][AW-1:0]      cfg_dev_base, cfg_dev_limit;
    logic                    cfg_vt_en, cfg_gfx_en;
    logic [2:0][AW-1:0]      cfg_rmp_base, cfg_rmp_limit;
    logic [1:0][AW-1:0]      cfg_gfx_base, cfg_gfx_limit;
    logic [2*NPORT-1:0][AW-1:0] cfg_port_base, cfg_port_limit;
    logic                    dst_valid, dst_illegal, dst_bypass_remap, cfg_err;
    logic [NDST-1:0]         dst_route;

    int total = 0;
    int bad   = 0;

    host_addr_decoder #(.AW(AW), .NPORT(NPORT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_from_engine(req_from_engine), .cfg_tom(cfg_tom), .cfg_stolen(cfg_stolen),
        .cfg_tolud(cfg_tolud), .cfg_dev_en(cfg_dev_en), .cfg_dev_base(cfg_dev_base),
        .cfg_dev_limit(cfg_dev_limit), .cfg_vt_en(cfg_vt_en), .cfg_rmp_base(cfg_rmp_base),
        .cfg_rmp_limit(cfg_rmp_limit), .cfg_gfx_en(cfg_gfx_en), .cfg_gfx_base(cfg_gfx_base),
        .cfg_gfx_limit(cfg_gfx_limit), .cfg_port_base(cfg_port_base),
        .cfg_port_limit(cfg_port_limit), .dst_valid(dst_valid), .dst_route(dst_route),
        .dst_illegal(dst_illegal), .dst_bypass_remap(dst_bypass_remap), .cfg_err(cfg_err));

    task automatic base_cfg();
        cfg_tom    = 36'h1_8000_0000;
        cfg_stolen = 36'h0_0400_0000;
        cfg_tolud  = 36'h0_C000_0000;
        cfg_dev_en = 3'b111;
        cfg_dev_base[0] = 36'hD000_0000; cfg_dev_limit[0] = 36'hD000_0FFF;
        cfg_dev_base[1] = 36'hD000_1000; cfg_dev_limit[1] = 36'hD000_7FFF;
        cfg_dev_base[2] = 36'hD000_8000; cfg_dev_limit[2] = 36'hD000_8FFF;
        cfg_vt_en = 1'b1;
        cfg_rmp_base[0] = 36'hD001_0000; cfg_rmp_limit[0] = 36'hD001_0FFF;
        cfg_rmp_base[1] = 36'hD001_1000; cfg_rmp_limit[1] = 36'hD001_1FFF;
        cfg_rmp_base[2] = 36'hD001_2000; cfg_rmp_limit[2] = 36'hD001_2FFF;
        cfg_gfx_en = 1'b1;
        cfg_gfx_base[0] = 36'hE000_0000; cfg_gfx_limit[0] = 36'hEFFF_FFFF;
        cfg_gfx_base[1] = 36'hD040_0000; cfg_gfx_limit[1] = 36'hD07F_FFFF;
        cfg_port_base[0] = 36'hC000_0000; cfg_port_limit[0] = 36'hC0FF_FFFF;
        cfg_port_base[1] = 36'hC800_0000; cfg_port_limit[1] = 36'hCBFF_FFFF;
        cfg_port_base[2] = 36'hC100_0000; cfg_port_limit[2] = 36'hC1FF_FFFF;
        cfg_port_base[3] = 36'hCC00_0000; cfg_port_limit[3] = 36'hCB00_0000;
    endtask

    task automatic fail_line(input string tag, input string what,
                             input logic [63:0] act, input logic [63:0] exp);
        bad++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    // Drive on a falling edge, one rising edge registers it, read at the next falling edge.
    task automatic probe(input logic [AW-1:0] a, input logic eng, input int exp_bit,
                         input logic exp_ill, input logic exp_byp, input string tag);
        logic [NDST-1:0] exp_route;
        exp_route = '0;
        if (exp_bit >= 0) exp_route[exp_bit] = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_from_engine = eng;
        @(negedge clk);
        total++;
        if (dst_valid !== 1'b1) fail_line(tag, "valid", 64'(dst_valid), 64'd1);
        else if (dst_route !== exp_route) fail_line(tag, "route", 64'(dst_route), 64'(exp_route));
        else if (dst_illegal !== exp_ill) fail_line(tag, "illegal", 64'(dst_illegal), 64'(exp_ill));
        else if (dst_bypass_remap !== exp_byp) fail_line(tag, "bypass", 64'(dst_bypass_remap), 64'(exp_byp));
        req_valid = 1'b0;
    endtask

    task automatic check_err(input logic exp, input string tag);
        @(negedge clk);
        total++;
        if (cfg_err !== exp) fail_line(tag, "cfg_err", 64'(cfg_err), 64'(exp));
    endtask

    task automatic t_reset();
        total++;
        if (dst_valid !== 1'b0 || dst_route !== '0 || dst_illegal !== 1'b0 || cfg_err !== 1'b0)
            fail_line("R1", "reset state", {dst_valid, dst_illegal, cfg_err, 8'(dst_route)}, 64'd0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        @(negedge clk);
        total++;
        if (dst_valid !== 1'b0 || dst_route !== '0)
            fail_line("R1", "idle output", 64'(dst_route), 64'd0);
    endtask

    task automatic t_dram();
        probe(36'h0_0000_0000, 1'b0, 0, 1'b0, 1'b0, "R4");
        probe(36'h0_BFFF_FFFF, 1'b0, 0, 1'b0, 1'b0, "R4");
        probe(36'h1_0000_0000, 1'b0, 0, 1'b0, 1'b0, "R4");
        probe(36'h1_7BFF_FFFF, 1'b1, 0, 1'b0, 1'b0, "R4");
        probe(36'h1_8000_0000, 1'b0, 5, 1'b0, 1'b0, "R4");
    endtask

    task automatic t_private();
        probe(36'h1_7C00_0000, 1'b1, 1, 1'b0, 1'b1, "R2");
        probe(36'h1_7FFF_FFFF, 1'b1, 1, 1'b0, 1'b1, "R2");
        probe(36'h1_7C00_0000, 1'b0, NONE, 1'b1, 1'b0, "R3");
        probe(36'h1_7FFF_FFFF, 1'b0, NONE, 1'b1, 1'b0, "R3");
    endtask

    task automatic t_hole_default();
        probe(36'h0_F000_0000, 1'b0, 5, 1'b0, 1'b0, "R5");
        probe(36'h0_FEC0_0000, 1'b0, 5, 1'b0, 1'b0, "R5");
        probe(36'h0_FFFF_FFFF, 1'b0, 5, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_device();
        probe(36'h0_D000_0000, 1'b0, 2, 1'b0, 1'b0, "R6");
        probe(36'h0_D000_8FFF, 1'b0, 2, 1'b0, 1'b0, "R6");
        cfg_dev_en = 3'b101;
        probe(36'h0_D000_4000, 1'b0, 5, 1'b0, 1'b0, "R6");
        cfg_dev_en = 3'b111;
    endtask

    task automatic t_remap();
        probe(36'h0_D001_2FFF, 1'b0, 3, 1'b0, 1'b0, "R7");
        cfg_vt_en = 1'b0;
        probe(36'h0_D001_2FFF, 1'b0, 5, 1'b0, 1'b0, "R7");
        cfg_vt_en = 1'b1;
    endtask

    task automatic t_graphics();
        probe(36'h0_E000_0000, 1'b0, 4, 1'b0, 1'b0, "R8");
        probe(36'h0_EFFF_FFFF, 1'b0, 4, 1'b0, 1'b0, "R8");
        probe(36'h0_D07F_FFFF, 1'b0, 4, 1'b0, 1'b0, "R8");
        cfg_gfx_en = 1'b0;
        probe(36'h0_E000_0000, 1'b0, 5, 1'b0, 1'b0, "R8");
        cfg_gfx_en = 1'b1;
    endtask

    task automatic t_ports();
        probe(36'h0_C000_0000, 1'b0, 6, 1'b0, 1'b0, "R9");
        probe(36'h0_CBFF_FFFF, 1'b0, 6, 1'b0, 1'b0, "R9");
        probe(36'h0_C1FF_FFFF, 1'b0, 7, 1'b0, 1'b0, "R9");
        cfg_port_base[3] = 36'hC000_0000; cfg_port_limit[3] = 36'hC000_FFFF;
        probe(36'h0_C000_0100, 1'b0, 6, 1'b0, 1'b0, "R9");
        base_cfg();
    endtask

    task automatic t_bounds();
        probe(36'h0_CC00_0000, 1'b0, 5, 1'b0, 1'b0, "R11");
        probe(36'h0_C200_0000, 1'b0, 5, 1'b0, 1'b0, "R11");
        probe(36'h0_D000_9000, 1'b0, 5, 1'b0, 1'b0, "R11");
        probe(36'h0_D001_3000, 1'b0, 5, 1'b0, 1'b0, "R11");
    endtask

    task automatic t_priority();
        cfg_dev_base[0] = 36'hE000_0000; cfg_dev_limit[0] = 36'hE000_0FFF;
        cfg_rmp_base[0] = 36'hE000_0000; cfg_rmp_limit[0] = 36'hE000_FFFF;
        probe(36'h0_E000_0800, 1'b0, 2, 1'b0, 1'b0, "R10");
        probe(36'h0_E000_8000, 1'b0, 3, 1'b0, 1'b0, "R10");
        cfg_gfx_base[1] = 36'hC800_0000; cfg_gfx_limit[1] = 36'hC80F_FFFF;
        probe(36'h0_C800_0000, 1'b0, 4, 1'b0, 1'b0, "R10");
        probe(36'h0_C810_0000, 1'b0, 6, 1'b0, 1'b0, "R10");
        base_cfg();
    endtask

    task automatic t_cfg_err();
        @(negedge clk);
        check_err(1'b0, "R12");
        cfg_gfx_limit[0] = 36'hFEC0_0000;
        check_err(1'b1, "R12");
        cfg_gfx_en = 1'b0;
        check_err(1'b0, "R12");
        cfg_gfx_en = 1'b1;
        cfg_gfx_limit[0] = 36'hEFFF_FFFF;
        cfg_port_base[3] = 36'hFEEF_F000; cfg_port_limit[3] = 36'hFEEF_FFFF;
        check_err(1'b1, "R12");
        cfg_port_base[3] = 36'hFFFF_0000; cfg_port_limit[3] = 36'hFEEF_FFFF;
        check_err(1'b0, "R12");
        cfg_port_base[3] = 36'hFEBF_0000; cfg_port_limit[3] = 36'hFEBF_FFFF;
        check_err(1'b0, "R12");
        base_cfg();
    endtask

    initial begin
        base_cfg();
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_dram();
        t_private();
        t_hole_default();
        t_device();
        t_remap();
        t_graphics();
        t_ports();
        t_bounds();
        t_priority();
        t_cfg_err();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule